// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Register Pair

This unit performs 32-bit integer multiplication and division over many clock cycles and keeps its results in two architectural registers, HI and LO. A core issues an operation by raising a one-cycle start strobe together with an operation code and two operands. The unit takes the operands on that edge and then works for one cycle per operand bit. A multiply leaves the full 64-bit product split across HI (upper half) and LO (lower half). A divide leaves the quotient in LO and the remainder in HI.

While an operation is in flight the unit raises `busy_o`. The surrounding pipeline uses it to hold back any instruction that reads HI or LO. Two write strobes let software load either register directly from a data bus. Division never traps. A zero divisor and the one signed overflow case give fixed, well-defined register contents, and these follow directly from the restoring divider and the sign correction. A new start strobe that arrives while the unit is busy abandons the running operation and begins the new one.

Top module: `muldiv_unit`

## Requirements
- R1: Out of reset, `hi_o` and `lo_o` read zero and `busy_o` is low.
- R2: `busy_o` is high from the clock edge that samples `start_i` and stays high for exactly 32 cycles. At the edge that ends those 32 cycles, `busy_o` falls and the result appears on `hi_o`/`lo_o`.
- R3: With `op_i` = 2'b01 (unsigned multiply), the result is the unsigned 64-bit product, with bits 63:32 in HI and bits 31:0 in LO.
- R4: With `op_i` = 2'b00 (signed multiply), the result is the two's-complement 64-bit product, split the same way.
- R5: With `op_i` = 2'b11 (unsigned divide) and a non-zero divisor, LO holds the unsigned quotient and HI holds the remainder.
- R6: With `op_i` = 2'b10 (signed divide) and a non-zero divisor, the quotient is truncated toward zero and the remainder carries the sign of the dividend.
- R7: An unsigned divide by zero gives HI = dividend and LO = 32'hFFFFFFFF.
- R8: A signed divide by zero gives HI = dividend. LO is 32'hFFFFFFFF when the dividend is non-negative and 32'h00000001 when it is negative.
- R9: A signed divide of 32'h80000000 by 32'hFFFFFFFF gives HI = 0 and LO = 32'h80000000.
- R10: `hi_wr_i` loads `wdata_i` into HI on the next edge, and `lo_wr_i` loads it into LO. The other register keeps its value.
- R11: A start strobe while `busy_o` is high discards the running operation. Only the new operation's result is written, 32 cycles after the new strobe.
- R12: Apart from direct writes, HI and LO do not change while an operation is running. They change only at its completing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| start_i | input | 1 | One-cycle strobe that starts an operation |
| op_i | input | 2 | 00 signed multiply, 01 unsigned multiply, 10 signed divide, 11 unsigned divide |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| hi_wr_i | input | 1 | Direct write strobe for HI |
| lo_wr_i | input | 1 | Direct write strobe for LO |
| wdata_i | input | 32 | Data for direct writes |
| hi_o | output | 32 | HI register |
| lo_o | output | 32 | LO register |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench targets the sign-handling corners: a product of two most-negative operands, mixed-sign divides, and the zero-divisor and overflow divides. A design that sign-corrected the wrong way would return the magnitude, or the negated value, of the quotient or remainder, and a design with a special-case table in the wrong order would return zero or the dividend in LO. The busy window is counted cycle by cycle, so a unit that finishes one cycle early or late is caught. A mid-flight restart checks that the abandoned multiply never lands in HI/LO. HI and LO are also sampled in the middle of an operation to catch partial results leaking out early.

// File: rtl/md_pkg.sv
package md_pkg;

  typedef enum logic [1:0] {
    MD_SMUL = 2'b00,
    MD_UMUL = 2'b01,
    MD_SDIV = 2'b10,
    MD_UDIV = 2'b11
  } md_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } md_state_e;

endpackage

// File: rtl/md_operand_prep.sv
module md_operand_prep #(
  parameter int W = 32
) (
  input  md_pkg::md_op_e op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   a_mag_o,
  output logic [W-1:0]   b_mag_o,
  output logic           neg_main_o,
  output logic           neg_rem_o,
  output logic           is_div_o
);
  import md_pkg::*;

  logic is_signed;
  logic a_neg;
  logic b_neg;

  always_comb begin
    is_signed  = (op_i == MD_SMUL) || (op_i == MD_SDIV);
    is_div_o   = (op_i == MD_SDIV) || (op_i == MD_UDIV);
    a_neg      = is_signed & a_i[W-1];
    b_neg      = is_signed & b_i[W-1];
    // magnitude of the most negative value is its own unsigned pattern
    a_mag_o    = a_neg ? (~a_i + 1'b1) : a_i;
    b_mag_o    = b_neg ? (~b_i + 1'b1) : b_i;
    neg_main_o = a_neg ^ b_neg;
    neg_rem_o  = a_neg;
  end

endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_nxt_o
);

  logic [W-1:0] acc_q, acc_n;
  logic [W-1:0] low_q, low_n;
  logic [W-1:0] mcand_q, mcand_n;
  logic [W:0]   sum;
  logic         en;

  // one shift-add iteration per step
  always_comb begin
    sum     = {1'b0, acc_q} + (low_q[0] ? {1'b0, mcand_q} : '0);
    acc_n   = sum[W:1];
    low_n   = {sum[0], low_q[W-1:1]};
    mcand_n = mcand_q;
    if (load_i) begin
      acc_n   = '0;
      low_n   = mplier_i;
      mcand_n = mcand_i;
    end
    en         = load_i | step_i;
    prod_nxt_o = {acc_n, low_n};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      low_q   <= '0;
      mcand_q <= '0;
    end else if (en) begin
      acc_q   <= acc_n;
      low_q   <= low_n;
      mcand_q <= mcand_n;
    end
  end

endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_nxt_o,
  output logic [W-1:0] rem_nxt_o
);

  logic [W-1:0] rem_q, rem_n;
  logic [W-1:0] quo_q, quo_n;
  logic [W-1:0] dvs_q, dvs_n;
  logic [W:0]   trial;
  logic [W:0]   diff;
  logic         fits;
  logic         en;

  // restoring division: one quotient bit per step, MSB first.
  // A zero divisor always fits, which yields all-ones quotient and
  // the dividend as remainder.
  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = ~diff[W];
    rem_n = fits ? diff[W-1:0] : trial[W-1:0];
    quo_n = {quo_q[W-2:0], fits};
    dvs_n = dvs_q;
    if (load_i) begin
      rem_n = '0;
      quo_n = dvd_i;
      dvs_n = dvs_i;
    end
    en        = load_i | step_i;
    quo_nxt_o = quo_n;
    rem_nxt_o = rem_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (en) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      dvs_q <= dvs_n;
    end
  end

  // R5: the partial remainder never reaches a non-zero divisor
  a_r5_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         hi_wr_i,
  input  logic         lo_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         busy_o
);
  import md_pkg::*;

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(W);
  localparam logic [CW-1:0] CNT_LAST = CW'(1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  md_op_e    op;
  md_state_e state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic       is_div_q, is_div_n;
  logic       neg_main_q, neg_main_n;
  logic       neg_rem_q, neg_rem_n;
  logic       ctl_en;
  logic       running;
  logic       finish;

  logic [W-1:0]   a_mag, b_mag;
  logic           p_neg_main, p_neg_rem, p_is_div;
  logic [2*W-1:0] prod_nxt;
  logic [W-1:0]   quo_nxt, rem_nxt;
  logic [2*W-1:0] prod_fix;
  logic [W-1:0]   quo_fix, rem_fix;

  logic [W-1:0] hi_q, hi_n, lo_q, lo_n;
  logic         hi_en, lo_en;

  assign op = md_op_e'(op_i);

  md_operand_prep #(.W(W)) prep_i (
    .op_i       (op),
    .a_i        (opa_i),
    .b_i        (opb_i),
    .a_mag_o    (a_mag),
    .b_mag_o    (b_mag),
    .neg_main_o (p_neg_main),
    .neg_rem_o  (p_neg_rem),
    .is_div_o   (p_is_div)
  );

  md_mul_core #(.W(W)) mul_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (start_i),
    .step_i     (running),
    .mcand_i    (a_mag),
    .mplier_i   (b_mag),
    .prod_nxt_o (prod_nxt)
  );

  md_div_core #(.W(W)) div_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .load_i    (start_i),
    .step_i    (running),
    .dvd_i     (a_mag),
    .dvs_i     (b_mag),
    .quo_nxt_o (quo_nxt),
    .rem_nxt_o (rem_nxt)
  );

  // sequencing: next-state logic
  always_comb begin
    running    = (state_q == ST_RUN);
    finish     = running && (cnt_q == CNT_LAST) && !start_i;
    state_n    = state_q;
    cnt_n      = cnt_q;
    is_div_n   = is_div_q;
    neg_main_n = neg_main_q;
    neg_rem_n  = neg_rem_q;
    if (start_i) begin
      state_n    = ST_RUN;
      cnt_n      = CNT_INIT;
      is_div_n   = p_is_div;
      neg_main_n = p_neg_main;
      neg_rem_n  = p_neg_rem;
    end else if (running) begin
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CNT_LAST) state_n = ST_IDLE;
    end
    ctl_en = start_i | running;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      is_div_q   <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
    end else if (ctl_en) begin
      state_q    <= state_n;
      cnt_q      <= cnt_n;
      is_div_q   <= is_div_n;
      neg_main_q <= neg_main_n;
      neg_rem_q  <= neg_rem_n;
    end
  end

  // sign correction of the final iteration's values
  always_comb begin
    prod_fix = neg_main_q ? (~prod_nxt + 1'b1) : prod_nxt;
    quo_fix  = neg_main_q ? (~quo_nxt + 1'b1) : quo_nxt;
    rem_fix  = neg_rem_q  ? (~rem_nxt + 1'b1) : rem_nxt;
  end

  // result registers: direct writes win over a completing operation
  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (finish) begin
      hi_n = is_div_q ? rem_fix : prod_fix[2*W-1:W];
      lo_n = is_div_q ? quo_fix : prod_fix[W-1:0];
    end
    if (hi_wr_i) hi_n = wdata_i;
    if (lo_wr_i) lo_n = wdata_i;
    hi_en = finish | hi_wr_i;
    lo_en = finish | lo_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_n;
      if (lo_en) lo_q <= lo_n;
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign busy_o = running;

  // R2: busy follows a start and drops after the last iteration
  a_r2_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> busy_o);

  a_r2_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && (cnt_q == CNT_LAST) && !start_i) |=> !busy_o);

  a_r2_count_range: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_o |-> ((cnt_q != '0) && (cnt_q <= CNT_INIT)));

  // R10: direct writes land on the next edge
  a_r10_hi_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    hi_wr_i |=> (hi_o == $past(wdata_i)));

  a_r10_lo_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    lo_wr_i |=> (lo_o == $past(wdata_i)));

  // R12: no change except at completion or on a direct write
  a_r12_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!hi_wr_i && !(busy_o && (cnt_q == CNT_LAST) && !start_i)) |=> $stable(hi_o));

  a_r12_lo_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!lo_wr_i && !(busy_o && (cnt_q == CNT_LAST) && !start_i)) |=> $stable(lo_o));

endmodule

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [1:0]   op;
  logic [W-1:0] opa, opb;
  logic         hi_wr, lo_wr;
  logic [W-1:0] wdata;
  logic [W-1:0] hi, lo;
  logic         busy;

  int total;
  int bad;
  bit finished;

  typedef struct {
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    string        tag;
  } exp_t;

  exp_t sb_q[$];

  muldiv_unit #(.W(W)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .op_i    (op),
    .opa_i   (opa),
    .opb_i   (opb),
    .hi_wr_i (hi_wr),
    .lo_wr_i (lo_wr),
    .wdata_i (wdata),
    .hi_o    (hi),
    .lo_o    (lo),
    .busy_o  (busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, written from the requirements
  function automatic exp_t model(input logic [1:0] o, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input string tag);
    exp_t e;
    logic [63:0] xa, xb, p;
    int sa, sb;
    e.tag = tag;
    sa = a;
    sb = b;
    case (o)
      2'b00: begin
        xa = {{32{a[31]}}, a};
        xb = {{32{b[31]}}, b};
        p = xa * xb;
        e.hi = p[63:32]; e.lo = p[31:0];
      end
      2'b01: begin
        p = {32'b0, a} * {32'b0, b};
        e.hi = p[63:32]; e.lo = p[31:0];
      end
      2'b10: begin
        if (b == 0) begin
          e.hi = a;
          e.lo = a[31] ? 32'h00000001 : 32'hFFFFFFFF;
        end else if (a == 32'h80000000 && b == 32'hFFFFFFFF) begin
          e.hi = 32'h0; e.lo = 32'h80000000;
        end else begin
          e.lo = sa / sb;
          e.hi = sa % sb;
        end
      end
      default: begin
        if (b == 0) begin
          e.hi = a; e.lo = 32'hFFFFFFFF;
        end else begin
          e.lo = a / b; e.hi = a % b;
        end
      end
    endcase
    return e;
  endfunction

  // driver: push expectation, strobe start, measure the busy window
  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag);
    int n;
    logic [W-1:0] pre_hi, pre_lo;
    sb_q.push_back(model(o, a, b, tag));
    pre_hi = hi;
    pre_lo = lo;
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      if (n == 20 && !(tag == "R11")) begin
        check({tag, " R12 hi mid-op"}, hi, pre_hi);
        check({tag, " R12 lo mid-op"}, lo, pre_lo);
      end
      @(negedge clk);
    end
    check({tag, " R2 busy cycles"}, n, 32);
    @(negedge clk);
  endtask

  // monitor: compare when busy falls
  bit prev_busy;
  always @(negedge clk) begin
    if (rst_n && prev_busy && !busy) begin
      if (sb_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R11 actual=unexpected result expected=none");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " hi"}, hi, e.hi);
        check({e.tag, " lo"}, lo, e.lo);
      end
    end
    prev_busy = busy;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog actual=hung expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; op = 2'b00; opa = '0; opb = '0;
    hi_wr = 1'b0; lo_wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 hi", hi, 32'h0);
    check("R1 lo", lo, 32'h0);
    check("R1 busy", busy, 1'b0);

    // R3 unsigned multiply
    run_op(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, "R3");
    run_op(2'b01, 32'h12345678, 32'h9ABCDEF0, "R3");
    // R4 signed multiply
    run_op(2'b00, 32'hFFFFFFFD, 32'd7, "R4");
    run_op(2'b00, 32'h80000000, 32'h80000000, "R4");
    run_op(2'b00, 32'hFFFFFFFB, 32'hFFFFFFFA, "R4");
    // R5 unsigned divide
    run_op(2'b11, 32'd100, 32'd7, "R5");
    run_op(2'b11, 32'hFFFFFFFF, 32'd16, "R5");
    // R6 signed divide, all sign combinations
    run_op(2'b10, 32'hFFFFFFF9, 32'd2, "R6");
    run_op(2'b10, 32'd7, 32'hFFFFFFFE, "R6");
    run_op(2'b10, 32'hFFFFFFF9, 32'hFFFFFFFE, "R6");
    // R7 unsigned divide by zero
    run_op(2'b11, 32'd1234, 32'd0, "R7");
    // R8 signed divide by zero
    run_op(2'b10, 32'd55, 32'd0, "R8");
    run_op(2'b10, 32'hFFFFFFF7, 32'd0, "R8");
    // R9 signed overflow
    run_op(2'b10, 32'h80000000, 32'hFFFFFFFF, "R9");

    // R10 direct writes, one register at a time
    @(negedge clk);
    begin
      logic [W-1:0] old_lo, old_hi;
      old_lo = lo;
      hi_wr = 1'b1; wdata = 32'hA5A5_1234;
      @(negedge clk);
      hi_wr = 1'b0;
      check("R10 hi written", hi, 32'hA5A5_1234);
      check("R10 lo untouched", lo, old_lo);
      old_hi = hi;
      lo_wr = 1'b1; wdata = 32'h0F0F_5678;
      @(negedge clk);
      lo_wr = 1'b0;
      check("R10 lo written", lo, 32'h0F0F_5678);
      check("R10 hi untouched", hi, old_hi);
    end

    // R11 abort: multiply started, then replaced by a divide
    @(negedge clk);
    start = 1'b1; op = 2'b01; opa = 32'd7; opb = 32'd9;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check("R11 still busy", busy, 1'b1);
    run_op(2'b11, 32'd1000, 32'd3, "R11");
    check("R11 queue drained", sb_q.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule